// File: doc/BRIEF.md
# Daylight Saving Hour Adjuster

This block sits beside the hours counter of a real-time clock. It reads the current date and time, and it looks for the one-second update strobe that is about to advance the time past 1:59:59 AM. On a spring transition Sunday it asks the hours counter to load 3 AM, so that the hour from 2 to 3 AM is skipped. On an autumn transition Sunday it asks the counter to load 1 AM, so that the hour from 1 to 2 AM is repeated. The minutes and seconds wrap to zero through the counter's normal increment. The adjustment is asked for with a load pulse and an override hour value. Both are combinational, and both are valid in the same cycle as the strobe.

The block works only when its enable input is high. It accepts hours in either 24-hour or 12-hour form, with the AM/PM flag in bit 7. It accepts every time and date field in either binary or BCD. The override value is returned in the same format as the inputs. An internal one-shot flag makes sure the autumn repeat happens only once. The block does not count dates and does not handle calendar rollover.

Top module: `dst_adjust`

## Requirements
- R1: While `dst_en` is 0, `hr_load_o` stays 0 for every input combination.
- R2: Spring rule. If `dst_en` and `tick` are both 1, the month is 4, the day of month is 1 to 7, the weekday code is 1 (1 means Sunday), and the time is 1:59:59 AM, then `hr_load_o` is 1 in that same cycle and `hr_value_o` is 3 AM in the input format.
- R3: Autumn rule. If `dst_en` and `tick` are both 1, the month is 10, the day of month is 25 to 31, the weekday code is 1, the time is 1:59:59 AM, and the one-shot is clear, then `hr_load_o` is 1 in that same cycle and `hr_value_o` is 1 AM in the input format.
- R4: An autumn load sets the one-shot, and further autumn matches are then ignored. The one-shot clears in any clock cycle in which the decoded hour is 2 or later in 24-hour terms.
- R5: When `fmt_24h` is 1, the hours field holds 0 to 23. When it is 0, the field holds 1 to 12 in bits 6:0 and bit 7 is 1 for PM. In that case 1:59:59 PM never triggers a load, and the override value has bit 7 cleared.
- R6: When `fmt_bin` is 1, all fields are plain binary. When it is 0, they are BCD with tens in bits 7:4 and units in bits 3:0. Matching uses the decoded values. For example, 59 minutes is 8'h3B in binary and 8'h59 in BCD.
- R7: `hr_load_o` is 1 only in a cycle in which `tick` is 1.
- R8: Any other date or time gives no load. This covers another month, a weekday other than 1, day 8 or later in April, day 24 or earlier in October, and any time other than 1:59:59.
- R9: Reset clears the one-shot, so the first autumn match after reset loads.
- R10: `hr_value_o` is 8'h00 whenever `hr_load_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second update strobe |
| dst_en | input | 1 | Enables daylight-saving adjustments |
| fmt_24h | input | 1 | 1 = 24-hour hours field, 0 = 12-hour with PM in bit 7 |
| fmt_bin | input | 1 | 1 = binary fields, 0 = BCD fields |
| month_i | input | 8 | Month, 1 to 12 |
| mday_i | input | 8 | Day of month, 1 to 31 |
| wday_i | input | 8 | Day of week, 1 to 7, where 1 is Sunday |
| hour_i | input | 8 | Current hour |
| min_i | input | 8 | Current minutes |
| sec_i | input | 8 | Current seconds |
| hr_load_o | output | 1 | Load pulse for the hours counter |
| hr_value_o | output | 8 | Hour to load, in the input format |

## Verification
The hardest state to reach is the autumn repeat that is held off by the one-shot. This needs two matching autumn strobes with no hour of 2 or later between them, and a uniform random draw almost never produces that. The bench therefore runs directed sequences. One sequence repeats the 1:59:59 strobe. Another holds the hour at 1 AM across several cycles and then steps to 2 AM to clear the one-shot. Another resets in the middle with the one-shot set. The random phase is biased toward 1:59:59, the months 4 and 10, and the weekday code 1. Its draws therefore land often on the transition windows and on their edges, in all four format combinations. A bench model of the one-shot follows every cycle.

// File: rtl/dst_pkg.sv
package dst_pkg;

  typedef struct packed {
    logic [7:0] month;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hour24;
    logic [7:0] minute;
    logic [7:0] second;
    logic       pm;
  } dst_time_t;

  // raw field -> binary value
  function automatic logic [7:0] field_to_bin(input logic [7:0] raw, input logic is_bin);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = {4'd0, raw[7:4]};
    ones = {4'd0, raw[3:0]};
    return is_bin ? raw : (tens * 8'd10) + ones;
  endfunction

  // binary value -> raw field
  function automatic logic [7:0] bin_to_field(input logic [7:0] val, input logic is_bin);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = val / 8'd10;
    ones = val % 8'd10;
    return is_bin ? val : {tens[3:0], ones[3:0]};
  endfunction

  // raw hours byte -> 0..23
  function automatic logic [7:0] hour_to_24(input logic [7:0] raw, input logic is_24h,
                                            input logic is_bin);
    logic [7:0] h12;
    if (is_24h) return field_to_bin(raw, is_bin);
    h12 = field_to_bin({1'b0, raw[6:0]}, is_bin);
    if (h12 == 8'd12) return raw[7] ? 8'd12 : 8'd0;
    return raw[7] ? h12 + 8'd12 : h12;
  endfunction

  // 0..23 -> raw hours byte
  function automatic logic [7:0] hour_from_24(input logic [7:0] h24, input logic is_24h,
                                              input logic is_bin);
    logic [7:0] h12;
    logic [7:0] enc;
    if (is_24h) return bin_to_field(h24, is_bin);
    h12 = (h24 % 8'd12 == 8'd0) ? 8'd12 : h24 % 8'd12;
    enc = bin_to_field(h12, is_bin);
    return {(h24 >= 8'd12), enc[6:0]};
  endfunction

endpackage

// File: rtl/dst_field_decode.sv
module dst_field_decode
  import dst_pkg::*;
(
  input  logic       fmt_24h,
  input  logic       fmt_bin,
  input  logic [7:0] month_i,
  input  logic [7:0] mday_i,
  input  logic [7:0] wday_i,
  input  logic [7:0] hour_i,
  input  logic [7:0] min_i,
  input  logic [7:0] sec_i,
  output dst_time_t  now_o
);

  always_comb begin
    now_o.month  = field_to_bin(month_i, fmt_bin);
    now_o.mday   = field_to_bin(mday_i, fmt_bin);
    now_o.wday   = field_to_bin(wday_i, fmt_bin);
    now_o.hour24 = hour_to_24(hour_i, fmt_24h, fmt_bin);
    now_o.minute = field_to_bin(min_i, fmt_bin);
    now_o.second = field_to_bin(sec_i, fmt_bin);
    now_o.pm     = !fmt_24h && hour_i[7];
  end

endmodule

// File: rtl/dst_rule_match.sv
module dst_rule_match
  import dst_pkg::*;
#(
  parameter int unsigned SPRING_MONTH  = 4,
  parameter int unsigned FALL_MONTH    = 10,
  parameter int unsigned WEEK_LEN      = 7,
  parameter int unsigned MONTH_LEN     = 31,
  parameter int unsigned SUNDAY_CODE   = 1,
  parameter int unsigned SWITCH_HOUR   = 1
) (
  input  dst_time_t now_i,
  output logic      spring_hit_o,
  output logic      fall_hit_o
);

  localparam logic [7:0] FirstWeekEnd  = 8'(WEEK_LEN);
  localparam logic [7:0] LastWeekStart = 8'(MONTH_LEN - WEEK_LEN + 1);
  localparam logic [7:0] LastMinSec    = 8'd59;

  logic at_switch_edge;
  logic sunday;
  logic first_week;
  logic last_week;

  always_comb begin
    at_switch_edge = (now_i.hour24 == 8'(SWITCH_HOUR)) && !now_i.pm
                     && (now_i.minute == LastMinSec) && (now_i.second == LastMinSec);
    sunday         = (now_i.wday == 8'(SUNDAY_CODE));
    first_week     = (now_i.mday >= 8'd1) && (now_i.mday <= FirstWeekEnd);
    last_week      = (now_i.mday >= LastWeekStart) && (now_i.mday <= 8'(MONTH_LEN));
    spring_hit_o   = at_switch_edge && sunday && first_week
                     && (now_i.month == 8'(SPRING_MONTH));
    fall_hit_o     = at_switch_edge && sunday && last_week
                     && (now_i.month == 8'(FALL_MONTH));
  end

  // the two rules live in different months, never both at once
  always_comb begin
    assert_rules_exclusive_R8: assert ($onehot0({spring_hit_o, fall_hit_o}));
  end

endmodule

// File: rtl/dst_oneshot.sv
module dst_oneshot (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic done_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     done_o <= 1'b0;
    else if (set_i) done_o <= 1'b1;
    else if (clr_i) done_o <= 1'b0;
  end

  assert_set_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> done_o);

endmodule

// File: rtl/dst_adjust.sv
module dst_adjust
  import dst_pkg::*;
#(
  parameter int unsigned SPRING_MONTH = 4,
  parameter int unsigned FALL_MONTH   = 10,
  parameter int unsigned WEEK_LEN     = 7,
  parameter int unsigned MONTH_LEN    = 31,
  parameter int unsigned SUNDAY_CODE  = 1,
  parameter int unsigned SWITCH_HOUR  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       dst_en,
  input  logic       fmt_24h,
  input  logic       fmt_bin,
  input  logic [7:0] month_i,
  input  logic [7:0] mday_i,
  input  logic [7:0] wday_i,
  input  logic [7:0] hour_i,
  input  logic [7:0] min_i,
  input  logic [7:0] sec_i,
  output logic       hr_load_o,
  output logic [7:0] hr_value_o
);

  localparam logic [7:0] SpringTarget = 8'(SWITCH_HOUR + 2);
  localparam logic [7:0] FallTarget   = 8'(SWITCH_HOUR);

  dst_time_t now;
  logic      spring_hit;
  logic      fall_hit;
  logic      fall_done;
  logic      spring_fire;
  logic      fall_fire;
  logic      past_switch;

  dst_field_decode u_decode (
    .fmt_24h (fmt_24h),
    .fmt_bin (fmt_bin),
    .month_i (month_i),
    .mday_i  (mday_i),
    .wday_i  (wday_i),
    .hour_i  (hour_i),
    .min_i   (min_i),
    .sec_i   (sec_i),
    .now_o   (now)
  );

  dst_rule_match #(
    .SPRING_MONTH (SPRING_MONTH),
    .FALL_MONTH   (FALL_MONTH),
    .WEEK_LEN     (WEEK_LEN),
    .MONTH_LEN    (MONTH_LEN),
    .SUNDAY_CODE  (SUNDAY_CODE),
    .SWITCH_HOUR  (SWITCH_HOUR)
  ) u_rules (
    .now_i        (now),
    .spring_hit_o (spring_hit),
    .fall_hit_o   (fall_hit)
  );

  assign spring_fire = tick && dst_en && spring_hit;
  assign fall_fire   = tick && dst_en && fall_hit && !fall_done;
  assign past_switch = now.hour24 > 8'(SWITCH_HOUR);

  dst_oneshot u_once (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (fall_fire),
    .clr_i  (past_switch),
    .done_o (fall_done)
  );

  always_comb begin
    hr_load_o  = spring_fire || fall_fire;
    hr_value_o = 8'h00;
    if (spring_fire)    hr_value_o = hour_from_24(SpringTarget, fmt_24h, fmt_bin);
    else if (fall_fire) hr_value_o = hour_from_24(FallTarget, fmt_24h, fmt_bin);
  end

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_en |-> !hr_load_o);

  assert_load_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hr_load_o |-> tick);

  assert_zero_idle_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hr_load_o |-> hr_value_o == 8'h00);

  assert_spring_lands_three_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spring_fire |-> hour_to_24(hr_value_o, fmt_24h, fmt_bin) == SpringTarget);

  assert_fall_lands_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_fire |-> hour_to_24(hr_value_o, fmt_24h, fmt_bin) == FallTarget);

  assert_fall_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_fire |=> !fall_fire);

  assert_am_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hr_load_o && !fmt_24h |-> !hr_value_o[7] && !hour_i[7]);

endmodule

// File: tb/dst_adjust_tb_top.sv
module dst_adjust_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       dst_en = 1'b0;
  logic       fmt_24h = 1'b1;
  logic       fmt_bin = 1'b1;
  logic [7:0] month_i = 8'd1;
  logic [7:0] mday_i = 8'd1;
  logic [7:0] wday_i = 8'd2;
  logic [7:0] hour_i = 8'd0;
  logic [7:0] min_i = 8'd0;
  logic [7:0] sec_i = 8'd0;
  logic       hr_load_o;
  logic [7:0] hr_value_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  m_once = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dst_adjust dut_i (
    .clk (clk), .rst_n (rst_n), .tick (tick), .dst_en (dst_en),
    .fmt_24h (fmt_24h), .fmt_bin (fmt_bin), .month_i (month_i), .mday_i (mday_i),
    .wday_i (wday_i), .hour_i (hour_i), .min_i (min_i), .sec_i (sec_i),
    .hr_load_o (hr_load_o), .hr_value_o (hr_value_o)
  );

  function automatic logic [7:0] enc(input int v, input bit b);
    return b ? 8'(v) : 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] enc_hr(input int h, input bit f24, input bit b);
    int h12;
    if (f24) return enc(h, b);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12, b) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive one cycle of abstract values, check outputs, update the one-shot model
  task automatic step(input bit en, input bit tk, input bit f24, input bit b, input int mo,
                      input int md, input int wd, input int h, input int mi, input int s,
                      input string tag);
    bit sp;
    bit fa;
    int  tgt;
    @(negedge clk);
    dst_en = en; tick = tk; fmt_24h = f24; fmt_bin = b;
    month_i = enc(mo, b); mday_i = enc(md, b); wday_i = enc(wd, b);
    hour_i = enc_hr(h, f24, b); min_i = enc(mi, b); sec_i = enc(s, b);
    #1;
    sp = en && tk && wd == 1 && h == 1 && mi == 59 && s == 59 && mo == 4 && md <= 7;
    fa = en && tk && wd == 1 && h == 1 && mi == 59 && s == 59 && mo == 10 && md >= 25
         && !m_once;
    tgt = sp ? 3 : 1;
    check({tag, " load"}, {7'd0, hr_load_o}, {7'd0, sp || fa});
    check({tag, " value"}, hr_value_o, (sp || fa) ? enc_hr(tgt, f24, b) : 8'h00);
    if (fa) m_once = 1'b1;
    else if (h >= 2) m_once = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; dst_en = 1'b0;
    m_once = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    // R9 reset state: idle output
    step(1, 0, 1, 1, 1, 1, 2, 0, 0, 0, "R9 idle");
    // R2 spring, every format
    for (int f = 0; f < 4; f++) begin
      step(1, 1, f[0], f[1], 4, 1 + f, 1, 1, 59, 59, "R2 spring");
    end
    step(1, 1, 1, 1, 4, 7, 1, 1, 59, 59, "R2 spring day7");
    // R3/R4 autumn once, repeat held, cleared by hour 2
    step(1, 1, 1, 0, 10, 25, 1, 1, 59, 59, "R3 fall");
    step(1, 0, 1, 0, 10, 25, 1, 1, 0, 0, "R4 hold");
    step(1, 1, 1, 0, 10, 25, 1, 1, 59, 59, "R4 repeat ignored");
    step(1, 0, 1, 0, 10, 25, 1, 2, 0, 0, "R4 clear");
    step(1, 1, 0, 1, 10, 31, 1, 1, 59, 59, "R3 fall again 12h");
    // R9 reset clears one-shot
    do_reset();
    step(1, 1, 1, 1, 10, 28, 1, 1, 59, 59, "R9 fall after reset");
    do_reset();
    // R1 disabled, R7 no tick
    step(0, 1, 1, 1, 4, 3, 1, 1, 59, 59, "R1 disabled");
    step(1, 0, 1, 1, 4, 3, 1, 1, 59, 59, "R7 no tick");
    // R5 PM ignored in 12h mode, R6 BCD matching
    step(1, 1, 0, 0, 4, 3, 1, 13, 59, 59, "R5 pm");
    step(1, 1, 0, 1, 4, 3, 1, 13, 59, 59, "R5 pm bin");
    step(1, 1, 1, 0, 4, 5, 1, 1, 59, 59, "R6 bcd spring");
    // R8 boundaries
    step(1, 1, 1, 1, 4, 8, 1, 1, 59, 59, "R8 april day8");
    step(1, 1, 1, 1, 10, 24, 1, 1, 59, 59, "R8 october day24");
    step(1, 1, 1, 1, 4, 2, 2, 1, 59, 59, "R8 monday");
    step(1, 1, 1, 1, 5, 2, 1, 1, 59, 59, "R8 may");
    step(1, 1, 1, 1, 4, 2, 1, 1, 59, 58, "R8 second58");
    step(1, 1, 1, 1, 4, 2, 1, 2, 59, 59, "R8 hour2");
    // R10 and mixed random
    for (int i = 0; i < 4000; i++) begin
      bit edge_t;
      int mo;
      int h;
      int mi;
      int s;
      edge_t = ($urandom % 2) == 0;
      mo = ($urandom % 2) ? (($urandom % 2) ? 4 : 10) : 1 + int'($urandom % 12);
      h  = edge_t ? (($urandom % 4 == 0) ? 13 : 1) : int'($urandom % 24);
      mi = edge_t ? 59 : int'($urandom % 60);
      s  = edge_t ? 59 : int'($urandom % 60);
      step(($urandom % 8) != 0, ($urandom % 4) != 0, $urandom % 2, $urandom % 2, mo,
           1 + int'($urandom % 31), ($urandom % 2) ? 1 : 1 + int'($urandom % 7),
           h, mi, s, "R10 R2 R3 R8 random");
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule